// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block is the digital divider chain of an integer-N frequency synthesizer. Everything runs on one fast input clock, and each clock edge stands in for one cycle of the oscillator being divided. A prescaler sub-counter divides that clock by either ten or eleven. A modulus-select line (`msel`) picks the ratio. A main counter counts prescaler cycles and sets the length of each feedback period. A swallow counter holds `msel` high for the first A prescaler cycles of every period. The result is a feedback division of 10·(M+1)+A, and each period ends with a single-cycle pulse on `fp`.

A separate reference counter divides a stream of reference strobes (`ref_tick`) by R+1 and marks each of its periods with a single-cycle pulse on `fc`. The division values arrive on a parallel configuration bus. Both counters take new values only at their own period boundary, so writing the bus in the middle of a period never shortens that period.

A sticky flag records any swallow count that cannot fit in the main period. A two-bit select routes `fp`, `fc` or `msel` to one debug pin.

Top module: `swallow_divider`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `fp`, `fc` and `cfg_err` are 0 and `msel` is 1 (divide by eleven).
- R2: After reset the active main and swallow values are zero. The first feedback period after `rst` falls therefore lasts 11 clocks, with `msel` high for all 11, and ends with `fp`.
- R3: For a loaded pair with A ≤ M+1, successive `fp` pulses are 10·(M+1)+A clocks apart.
- R4: Within a feedback period, `msel` is high for the first A prescaler cycles (11·A clocks) and low for the rest. It changes only at the end of a prescaler cycle.
- R5: `fp` is high for exactly one clock per feedback period.
- R6: With a reference strobe on every clock, successive `fc` pulses are R+1 clocks apart. `fc` is high only in the clock after a clock in which `ref_tick` was high.
- R7: The reference counter advances only on clocks with `ref_tick` high. With strobes every S clocks, the `fc` spacing is S·(R+1). With no strobes, `fc` stays low.
- R8: `cfg_m`, `cfg_a` and `cfg_r` are sampled only at the clock edge that ends the current period of their counter. A change in mid-period leaves the length of that period unchanged and applies to the next period.
- R9: A pair loaded with A > M+1 runs a period of 11·(M+1) clocks with `msel` high throughout. It sets `cfg_err` at that boundary, and `cfg_err` stays 1 until reset.
- R10: `dbg_sel` encodings: 0 routes `fp`, 1 routes `fc`, 2 routes `msel`, and 3 drives `dbg_out` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock (oscillator edges) |
| rst | input | 1 | Synchronous reset, active high |
| cfg_m | input | 9 | Main count M; period is M+1 prescaler cycles |
| cfg_a | input | 4 | Swallow count A; prescaler cycles at divide-by-eleven |
| cfg_r | input | 6 | Reference count R; reference ratio R+1 |
| ref_tick | input | 1 | One-clock strobe per reference edge |
| dbg_sel | input | 2 | Debug route select |
| fp | output | 1 | Feedback pulse, one clock per feedback period |
| fc | output | 1 | Comparison pulse, one clock per reference period |
| cfg_err | output | 1 | Sticky flag for a swallow count above M+1 |
| dbg_out | output | 1 | Selected debug signal |

## Verification
`fp` and `fc` are registered, so each pulse is visible at the falling edge that follows the boundary edge that raised it. The bench therefore measures each period as the number of falling edges from one pulse to the next. It counts `msel` (through `dbg_out`) at those same falling edges, from the pulse sample up to but not including the next pulse. A new configuration is loaded at the edge that raised the pulse. The bench therefore predicts the period that starts at a pulse from the bus value it held at that pulse, and writes new values a chosen number of clocks into the period. `cfg_err` is compared at each pulse, and the debug route is compared one nanosecond after a change of select, since the mux has no register.

// File: rtl/swallow_divider_pkg.sv
package swallow_divider_pkg;

  // Debug route select encodings
  typedef enum logic [1:0] {
    OBS_FP   = 2'd0,
    OBS_FC   = 2'd1,
    OBS_MSEL = 2'd2,
    OBS_NONE = 2'd3
  } obs_sel_e;

  // A swallow count larger than the number of prescaler cycles in a period cannot be honoured
  function automatic logic swallow_bad(input int unsigned m, input int unsigned a);
    return a > m + 1;
  endfunction

  // Total feedback division for a legal pair
  function automatic int unsigned fb_ratio(input int unsigned base, input int unsigned m,
                                           input int unsigned a);
    return base * (m + 1) + a;
  endfunction

endpackage

// File: rtl/swallow_divider_prescaler.sv
module swallow_divider_prescaler #(
  parameter int unsigned BASE = 10,
  localparam int unsigned CW = $clog2(BASE + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic wide_mode,   // 1: divide by BASE+1, 0: divide by BASE
  output logic cyc_done     // high on the last clock of each prescaler cycle
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb last = wide_mode ? CW'(BASE) : CW'(BASE - 1);

  assign cyc_done = (cnt == last);

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (cyc_done) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/swallow_divider_fbdiv.sv
module swallow_divider_fbdiv #(
  parameter int unsigned M_W = 9,
  parameter int unsigned A_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cyc_done,
  input  logic [M_W-1:0] cfg_m,
  input  logic [A_W-1:0] cfg_a,
  output logic           msel,
  output logic           period_end,
  output logic           fb_pulse
);

  logic [M_W-1:0] m_cnt;    // prescaler cycles completed in this period
  logic [M_W-1:0] m_lim;    // active main count
  logic [A_W-1:0] s_rem;    // wide cycles still owed after the current one
  logic           msel_q;
  logic           fp_q;

  assign period_end = cyc_done && (m_cnt == m_lim);
  assign msel       = msel_q;
  assign fb_pulse   = fp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_cnt  <= '0;
      m_lim  <= '0;
      s_rem  <= '0;
      msel_q <= 1'b1;
      fp_q   <= 1'b0;
    end else begin
      fp_q <= period_end;
      if (period_end) begin
        m_cnt  <= '0;
        m_lim  <= cfg_m;
        msel_q <= (cfg_a != '0);
        s_rem  <= (cfg_a != '0) ? cfg_a - 1'b1 : '0;
      end else if (cyc_done) begin
        m_cnt  <= m_cnt + 1'b1;
        msel_q <= (s_rem != '0);
        if (s_rem != '0) s_rem <= s_rem - 1'b1;
      end
    end
  end

endmodule

// File: rtl/swallow_divider_refdiv.sv
module swallow_divider_refdiv #(
  parameter int unsigned R_W = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ref_tick,
  input  logic [R_W-1:0] cfg_r,
  output logic           cmp_pulse
);

  logic [R_W-1:0] r_cnt;
  logic [R_W-1:0] r_lim;
  logic           hit;
  logic           fc_q;

  assign hit       = ref_tick && (r_cnt == r_lim);
  assign cmp_pulse = fc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_cnt <= '0;
      r_lim <= '0;
      fc_q  <= 1'b0;
    end else begin
      fc_q <= hit;
      if (hit) begin
        r_cnt <= '0;
        r_lim <= cfg_r;
      end else if (ref_tick) begin
        r_cnt <= r_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swallow_divider_pkg::*;
#(
  parameter int unsigned M_W      = 9,
  parameter int unsigned A_W      = 4,
  parameter int unsigned R_W      = 6,
  parameter int unsigned PRE_BASE = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M_W-1:0] cfg_m,
  input  logic [A_W-1:0] cfg_a,
  input  logic [R_W-1:0] cfg_r,
  input  logic           ref_tick,
  input  logic [1:0]     dbg_sel,
  output logic           fp,
  output logic           fc,
  output logic           cfg_err,
  output logic           dbg_out
);

  // Named internal events, also watched by the bound checker
  logic pre_done;
  logic msel;
  logic period_end;
  logic bad_load;
  logic err_q;

  swallow_divider_prescaler #(.BASE(PRE_BASE)) i_pre (
    .clk      (clk),
    .rst      (rst),
    .wide_mode(msel),
    .cyc_done (pre_done)
  );

  swallow_divider_fbdiv #(.M_W(M_W), .A_W(A_W)) i_fb (
    .clk       (clk),
    .rst       (rst),
    .cyc_done  (pre_done),
    .cfg_m     (cfg_m),
    .cfg_a     (cfg_a),
    .msel      (msel),
    .period_end(period_end),
    .fb_pulse  (fp)
  );

  swallow_divider_refdiv #(.R_W(R_W)) i_ref (
    .clk      (clk),
    .rst      (rst),
    .ref_tick (ref_tick),
    .cfg_r    (cfg_r),
    .cmp_pulse(fc)
  );

  assign bad_load = period_end && swallow_bad(32'(cfg_m), 32'(cfg_a));

  always_ff @(posedge clk) begin
    if (rst)           err_q <= 1'b0;
    else if (bad_load) err_q <= 1'b1;
  end

  assign cfg_err = err_q;

  always_comb begin
    unique case (obs_sel_e'(dbg_sel))
      OBS_FP:   dbg_out = fp;
      OBS_FC:   dbg_out = fc;
      OBS_MSEL: dbg_out = msel;
      default:  dbg_out = 1'b0;
    endcase
  end

endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk (
  input logic clk,
  input logic rst,
  input logic pre_done,
  input logic msel,
  input logic fp,
  input logic fc,
  input logic ref_tick,
  input logic cfg_err
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (msel && !fp && !fc && !cfg_err));

  // R4
  msel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pre_done |=> $stable(msel));

  // R5
  fp_single_chk: assert property (@(posedge clk) disable iff (rst)
    fp |=> !fp);

  // R6
  fc_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    fc |-> $past(ref_tick));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

endmodule

bind swallow_divider swallow_divider_chk i_chk (
  .clk     (clk),
  .rst     (rst),
  .pre_done(pre_done),
  .msel    (msel),
  .fp      (fp),
  .fc      (fc),
  .ref_tick(ref_tick),
  .cfg_err (cfg_err)
);

// File: tb/test_swallow_divider.sv
module test_swallow_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] cfg_m = '0;
  logic [3:0] cfg_a = '0;
  logic [5:0] cfg_r = '0;
  logic       ref_tick = 1'b0;
  logic [1:0] dbg_sel = 2'd2;
  logic       fp, fc, cfg_err, dbg_out;

  swallow_divider i_swallow_divider (
    .clk(clk), .rst(rst), .cfg_m(cfg_m), .cfg_a(cfg_a), .cfg_r(cfg_r),
    .ref_tick(ref_tick), .dbg_sel(dbg_sel), .fp(fp), .fc(fc),
    .cfg_err(cfg_err), .dbg_out(dbg_out)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int ref_sp = 0;
  int phase = 0;
  int exp_err = 0;

  // Expected period: every prescaler cycle is 10 clocks, plus one per swallowed cycle,
  // and an oversized swallow count turns every cycle into an 11-clock one.
  function automatic int want_len(int m, int a);
    if (a > m + 1) return 11 * (m + 1);
    return 10 * m + 10 + a;
  endfunction

  function automatic int want_hi(int m, int a);
    if (a > m + 1) return 11 * (m + 1);
    return 11 * a;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    phase++;
    if (ref_sp == 0) ref_tick = 1'b0;
    else             ref_tick = (phase % ref_sp) == 0;
  endtask

  // From an fp sample to the next: length and msel-high count; new cfg at sample number chg
  task automatic run_period(input int chg, input int nm, input int na,
                            output int len, output int hi, output int sfp);
    len = 0; hi = 0; sfp = 0;
    do begin
      if (len + 1 == chg) begin
        cfg_m = nm[8:0];
        cfg_a = na[3:0];
      end
      hi += int'(dbg_out);
      len++;
      step();
      if (len == 1) sfp = int'(fp);
    end while (!fp && len < 20000);
  endtask

  task automatic one_period(input int nm, input int na, input int chg);
    int cm, ca, len, hi, sfp;
    string tag;
    cm = int'(cfg_m);
    ca = int'(cfg_a);
    if (ca > cm + 1) exp_err = 1;
    check("R9", int'(cfg_err), exp_err, "sticky error at boundary");
    run_period(chg, nm, na, len, hi, sfp);
    tag = (ca > cm + 1) ? "R9" : ((chg > 1) ? "R3 R8" : "R3");
    check(tag, len, want_len(cm, ca), $sformatf("period m=%0d a=%0d", cm, ca));
    check("R4", hi, want_hi(cm, ca), $sformatf("msel high clocks m=%0d a=%0d", cm, ca));
    check("R5", sfp, 0, "fp width");
  endtask

  task automatic run_ref(input int chg, input int nr, output int len);
    len = 0;
    do begin
      if (len + 1 == chg) cfg_r = nr[5:0];
      len++;
      step();
    end while (!fc && len < 20000);
  endtask

  task automatic one_ref(input int nr, input int chg);
    int cr, len;
    cr = int'(cfg_r);
    run_ref(chg, nr, len);
    check((ref_sp > 1) ? "R7" : ((chg > 1) ? "R6 R8" : "R6"), len, (cr + 1) * ref_sp,
          $sformatf("fc spacing r=%0d stride=%0d", cr, ref_sp));
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int len, hi, sfp, junk, m, a;
    junk = int'($urandom(32'd20240611));

    // R1: reset state
    cfg_m = 9'd3; cfg_a = 4'd2; cfg_r = 6'd4;
    rst = 1'b1;
    repeat (4) step();
    check("R1", int'(fp), 0, "fp in reset");
    check("R1", int'(fc), 0, "fc in reset");
    check("R1", int'(cfg_err), 0, "err in reset");
    check("R1", int'(dbg_out), 1, "msel in reset");
    rst = 1'b0;

    // R2: priming period
    run_period(0, 0, 0, len, hi, sfp);
    check("R2", len, 11, "first period after reset");
    check("R2", hi, 11, "msel during first period");

    // Directed legal corners: A=0, M=0, A=M+1
    one_period(0, 0, 1);
    one_period(0, 1, 5);
    one_period(7, 8, 3);
    one_period(30, 0, 9);

    // Random legal pairs, new values written at varying points in the period
    for (int i = 0; i < 40; i++) begin
      m = int'($urandom_range(0, 40));
      a = int'($urandom_range(0, (m + 1 < 15) ? m + 1 : 15));
      one_period(m, a, int'($urandom_range(1, 10)));
    end

    // R10: debug routing, sampled at an fp clock then at a quiet one
    dbg_sel = 2'd0; #1;
    check("R10", int'(dbg_out), 1, "sel 0 carries fp");
    dbg_sel = 2'd3; #1;
    check("R10", int'(dbg_out), 0, "sel 3 is zero");
    dbg_sel = 2'd1; #1;
    check("R10", int'(dbg_out), int'(fc), "sel 1 carries fc");
    dbg_sel = 2'd2;
    step();
    dbg_sel = 2'd0; #1;
    check("R10", int'(dbg_out), 0, "sel 0 low between pulses");
    dbg_sel = 2'd2;
    run_period(0, 0, 0, len, hi, sfp);

    // Invalid swallow count, large main count, then random mix
    one_period(2, 5, 2);
    one_period(511, 15, 4);
    one_period(5, 0, 7);
    one_period(4, 3, 1);
    for (int i = 0; i < 12; i++) begin
      m = int'($urandom_range(0, 12));
      a = int'($urandom_range(0, 15));
      one_period(m, a, int'($urandom_range(1, 10)));
    end
    check("R9", int'(cfg_err), 1, "flag still set");

    // R9: reset clears the flag
    rst = 1'b1;
    repeat (3) step();
    check("R9", int'(cfg_err), 0, "flag cleared by reset");
    rst = 1'b0;
    exp_err = 0;
    cfg_m = 9'd1; cfg_a = 4'd1;
    run_period(0, 0, 0, len, hi, sfp);
    check("R2", len, 11, "priming after second reset");
    one_period(1, 1, 2);
    one_period(1, 1, 2);

    // R6: reference strobe on every clock
    ref_sp = 1;
    cfg_r = 6'd5;
    run_ref(0, 0, junk);
    one_ref(0, 1);
    one_ref(63, 1);
    one_ref(17, 30);
    for (int i = 0; i < 8; i++) one_ref(int'($urandom_range(0, 63)), 1);
    one_ref(9, 1);

    // R7: sparse strobes
    ref_sp = 3;
    run_ref(0, 0, junk);
    one_ref(4, 1);
    one_ref(0, 2);
    one_ref(6, 1);

    // R7: no strobes, no fc
    ref_sp = 0;
    ref_tick = 1'b0;
    junk = 0;
    repeat (300) begin
      step();
      junk += int'(fc);
    end
    check("R7", junk, 0, "fc pulses without strobes");

    finish_run();
  end

endmodule